// File: doc/BRIEF.md
# Address Window Chip-Select Decoder

This block decides, for every external bus access, which bus-timing parameter set applies and which chip-select line to pull low. Four address windows can each be programmed with a base address, a power-of-two size and an enable. An address that no enabled window covers falls back to a default region. When windows overlap, a fixed hierarchy resolves the conflict: window 4 beats window 3, and window 2 beats window 1. Between the two pairs, the upper pair beats the lower pair.

The decision is captured on the first clock edge of an access and then frozen until the access strobe drops. Downstream bus sequencing therefore sees a stable configuration index and a stable chip select for the whole access. The block also converts an external address-space limit into the number of segment address lines (from A16 upward) that the pads must drive. It raises a wait-stretch signal while an enabled ready input is held high during an access.

Top module: `addr_window_cs`

## Requirements
- R1: Window k matches when the address and its base agree on every bit at or above its size field. The size field is 5 bits and holds log2 of the window size in bytes. Values below 12 act as 12 (4 KB). Values of 24 or more match every address.
- R2: When more than one enabled window matches, the selected index is the highest-numbered matching window, giving the order 4, 3, 2, 1.
- R3: An access that no enabled window matches selects index 0 (the default region). A window whose enable bit is low never matches.
- R4: cs_n is active-low and has at most one bit low. Bit 0 is the default region and bit k is window k. During an access, the low bit is the one at position cfg_idx.
- R5: After reset, cs_n is all ones and cfg_idx is 0. After any clock edge at which acc_strobe is low, cs_n is all ones.
- R6: At the first clock edge at which acc_strobe is high, the block latches the index and chip select for acc_addr. Both stay unchanged while acc_strobe stays high, even if acc_addr changes.
- R7: seg_lines is 0, 2, 4 or 8 for space_sel 0 (64 KB), 1 (256 KB), 2 (1 MB) or 3 (16 MB).
- R8: wait_stretch is high exactly when an access is in progress, ready_en is high and ready_in is high. An access is in progress when a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | 24 | Address of the external access |
| acc_strobe | input | 1 | High for the duration of an access |
| win_base | input | 96 | Window bases, window k in bits [24k-1 -: 24] |
| win_size | input | 20 | Window log2 sizes, window k in bits [5k-1 -: 5] |
| win_en | input | 4 | Window enables, bit k-1 for window k |
| space_sel | input | 2 | External space limit code |
| ready_en | input | 1 | Enables the ready-driven wait stretch |
| ready_in | input | 1 | High requests wait states |
| cfg_idx | output | 3 | Selected configuration, 0 default, k window k |
| cs_n | output | 5 | Active-low chip selects |
| seg_lines | output | 4 | Number of segment address lines to drive |
| wait_stretch | output | 1 | Stretch the current access |

## Verification
On every cycle, the assertions check four things. The chip selects are never more than one-hot low. They go idle after a cycle without a strobe. They freeze together with the index while the strobe stays high. The wait stretch appears only under an enabled, high ready input during an access. Only the bench scenarios can show that the right window is chosen: nested and cross-pair overlaps, window edges, disabled windows and undersized size fields all need known configurations and expected indices. The segment line mapping likewise depends on a bench scenario.

// File: rtl/addr_window_cs_pkg.sv
package addr_window_cs_pkg;

   // log2 bytes of the smallest legal window
   localparam int unsigned MIN_SZ_LOG2 = 12;

   // returns the compare mask for one window: bits at or above the size
   function automatic logic [23:0] size_mask(input logic [4:0] sz);
      logic [23:0] m;
      int unsigned eff;
      eff = (sz < MIN_SZ_LOG2) ? MIN_SZ_LOG2 : int'(sz);
      for (int b = 0; b < 24; b++) begin
         m[b] = (b >= eff);
      end
      return m;
   endfunction

   // number of segment address lines for a space limit code
   function automatic logic [3:0] seg_count(input logic [1:0] code);
      logic [3:0] n;
      unique case (code)
         2'd0:    n = 4'd0;
         2'd1:    n = 4'd2;
         2'd2:    n = 4'd4;
         default: n = 4'd8;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/awc_win_match.sv
module awc_win_match
   import addr_window_cs_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned SZ_W   = 5
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [SZ_W-1:0]   size_log2,
   input  logic              enable,
   output logic              hit
);
   logic [ADDR_W-1:0] mask;

   always_comb begin
      mask = size_mask(size_log2);
      hit  = enable && ((addr & mask) == (base & mask));
   end
endmodule

// File: rtl/awc_prio.sv
module awc_prio #(
   parameter int unsigned NUM_WIN = 4,
   parameter int unsigned IDX_W   = 3
) (
   input  logic [NUM_WIN-1:0] hits,
   output logic [IDX_W-1:0]   idx
);
   // ascending scan: the last match is the highest-numbered window
   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (hits[i]) idx = IDX_W'(i + 1);
      end
   end
endmodule

// File: rtl/awc_cs_reg.sv
module awc_cs_reg #(
   parameter int unsigned NUM_CS = 5,
   parameter int unsigned IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [IDX_W-1:0]  idx_next,
   output logic [IDX_W-1:0]  idx_q,
   output logic [NUM_CS-1:0] cs_n_q,
   output logic              active_q
);
   logic [NUM_CS-1:0] onehot;

   always_comb begin
      onehot = '0;
      onehot[idx_next] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         cs_n_q   <= '1;
      end else if (!strobe) begin
         active_q <= 1'b0;
         cs_n_q   <= '1;
      end else if (!active_q) begin
         active_q <= 1'b1;
         idx_q    <= idx_next;
         cs_n_q   <= ~onehot;
      end
   end
endmodule

// File: rtl/addr_window_cs.sv
module addr_window_cs
   import addr_window_cs_pkg::*;
#(
   parameter int unsigned ADDR_W  = 24,
   parameter int unsigned NUM_WIN = 4,
   parameter int unsigned SZ_W    = 5,
   localparam int unsigned NUM_CS = NUM_WIN + 1,
   localparam int unsigned IDX_W  = $clog2(NUM_CS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         acc_addr,
   input  logic                      acc_strobe,
   input  logic [NUM_WIN*ADDR_W-1:0] win_base,
   input  logic [NUM_WIN*SZ_W-1:0]   win_size,
   input  logic [NUM_WIN-1:0]        win_en,
   input  logic [1:0]                space_sel,
   input  logic                      ready_en,
   input  logic                      ready_in,
   output logic [IDX_W-1:0]          cfg_idx,
   output logic [NUM_CS-1:0]         cs_n,
   output logic [3:0]                seg_lines,
   output logic                      wait_stretch
);
   if (ADDR_W != 24) begin : g_bad_addr
      $error("addr_window_cs: ADDR_W must be 24");
   end
   if (NUM_WIN != 4) begin : g_bad_win
      $error("addr_window_cs: the override hierarchy needs NUM_WIN of 4");
   end
   if (SZ_W != 5) begin : g_bad_sz
      $error("addr_window_cs: SZ_W must be 5");
   end

   logic [NUM_WIN-1:0] hits;
   logic [IDX_W-1:0]   idx_next;
   logic               active;

   for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
      awc_win_match #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_match (
         .addr      (acc_addr),
         .base      (win_base[k*ADDR_W +: ADDR_W]),
         .size_log2 (win_size[k*SZ_W +: SZ_W]),
         .enable    (win_en[k]),
         .hit       (hits[k])
      );
   end

   awc_prio #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_prio (
      .hits (hits),
      .idx  (idx_next)
   );

   awc_cs_reg #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_cs (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (acc_strobe),
      .idx_next (idx_next),
      .idx_q    (cfg_idx),
      .cs_n_q   (cs_n),
      .active_q (active)
   );

   assign seg_lines    = seg_count(space_sel);
   assign wait_stretch = active & ready_en & ready_in;
endmodule

// File: rtl/addr_window_cs_chk.sv
module addr_window_cs_chk #(
   parameter int unsigned NUM_CS = 5,
   parameter int unsigned IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_strobe,
   input logic              ready_en,
   input logic              ready_in,
   input logic [IDX_W-1:0]  cfg_idx,
   input logic [NUM_CS-1:0] cs_n,
   input logic              wait_stretch
);
   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n)) else $error("cs_n not one-hot low"); // R4

   AST_CS_MATCHES_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      !(&cs_n) |-> (cs_n[cfg_idx] == 1'b0)) else $error("cs_n disagrees with cfg_idx"); // R4

   AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_strobe |=> (&cs_n)) else $error("chip select left low without strobe"); // R5

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_strobe && $past(acc_strobe)) |=> ($stable(cs_n) && $stable(cfg_idx)))
      else $error("selection changed mid-access"); // R6

   AST_WAIT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      wait_stretch |-> (ready_en && ready_in && !(&cs_n))) else $error("spurious wait stretch"); // R8
endmodule

bind addr_window_cs addr_window_cs_chk #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_strobe   (acc_strobe),
   .ready_en     (ready_en),
   .ready_in     (ready_in),
   .cfg_idx      (cfg_idx),
   .cs_n         (cs_n),
   .wait_stretch (wait_stretch)
);

// File: tb/addr_window_cs_tb_top.sv
module addr_window_cs_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] acc_addr = '0;
   logic        acc_strobe = 1'b0;
   logic [95:0] win_base = '0;
   logic [19:0] win_size = '0;
   logic [3:0]  win_en = '0;
   logic [1:0]  space_sel = '0;
   logic        ready_en = 1'b0;
   logic        ready_in = 1'b0;
   logic [2:0]  cfg_idx;
   logic [4:0]  cs_n;
   logic [3:0]  seg_lines;
   logic        wait_stretch;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   addr_window_cs dut_i (
      .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_strobe(acc_strobe),
      .win_base(win_base), .win_size(win_size), .win_en(win_en),
      .space_sel(space_sel), .ready_en(ready_en), .ready_in(ready_in),
      .cfg_idx(cfg_idx), .cs_n(cs_n), .seg_lines(seg_lines),
      .wait_stretch(wait_stretch)
   );

   // {expected index, address}; windows set up by base_setup
   localparam logic [26:0] VEC [12] = '{
      {3'd0, 24'h000010}, {3'd1, 24'h100000}, {3'd1, 24'h1FFFFF},
      {3'd2, 24'h180000}, {3'd2, 24'h18FFFF}, {3'd1, 24'h190000},
      {3'd3, 24'h400000}, {3'd4, 24'h500000}, {3'd4, 24'h500FFF},
      {3'd3, 24'h501000}, {3'd0, 24'h800000}, {3'd0, 24'hFFFFFF}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_win(input int k, input logic [23:0] b, input logic [4:0] s, input bit e);
      win_base[(k-1)*24 +: 24] = b;
      win_size[(k-1)*5 +: 5]   = s;
      win_en[k-1]              = e;
   endtask

   task automatic base_setup();
      set_win(1, 24'h100000, 5'd20, 1'b1);
      set_win(2, 24'h180000, 5'd16, 1'b1);
      set_win(3, 24'h400000, 5'd22, 1'b1);
      set_win(4, 24'h500000, 5'd12, 1'b1);
   endtask

   // one access: strobe up at a negedge, check after the next posedge, then strobe down
   task automatic access(input logic [23:0] a, input logic [2:0] exp, input string req);
      @(negedge clk);
      acc_addr = a; acc_strobe = 1'b1;
      @(negedge clk);
      check(cfg_idx == exp, req, cfg_idx, exp);
      check(cs_n == ~(5'b1 << exp), req, cs_n, ~(5'b1 << exp));
      acc_strobe = 1'b0;
      @(negedge clk);
      check(cs_n == 5'h1F, "R5 idle", cs_n, 5'h1F);
   endtask

   initial begin : watchdog
      #200000;
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      base_setup();
      repeat (3) @(negedge clk);
      check(cs_n == 5'h1F, "R5 reset cs_n", cs_n, 5'h1F);
      check(cfg_idx == 3'd0, "R5 reset cfg_idx", cfg_idx, 0);
      rst_n = 1'b1;

      // R1 R2 R3 R4: table walk
      foreach (VEC[i]) access(VEC[i][23:0], VEC[i][26:24], "R1/R2 table");

      // R2: upper pair beats lower pair when window 3 covers window 1
      set_win(3, 24'h100000, 5'd20, 1'b1);
      access(24'h120000, 3'd3, "R2 cross pair 3 over 1");
      access(24'h180000, 3'd3, "R2 cross pair 3 over 2");
      base_setup();

      // R3: a disabled window never matches
      win_en[3] = 1'b0;
      access(24'h500000, 3'd3, "R3 disabled window 4");
      win_en = 4'b0000;
      access(24'h180000, 3'd0, "R3 all disabled default");
      base_setup();

      // R1: undersized field acts as 4 KB; size 24 covers all
      set_win(4, 24'h500000, 5'd3, 1'b1);
      access(24'h500800, 3'd4, "R1 clamp inside");
      access(24'h501000, 3'd3, "R1 clamp outside");
      set_win(4, 24'h000000, 5'd24, 1'b1);
      access(24'hABCDEF, 3'd4, "R1 full space");
      base_setup();

      // R6: address change mid-access has no effect
      @(negedge clk);
      acc_addr = 24'h180000; acc_strobe = 1'b1;
      @(negedge clk);
      acc_addr = 24'h500000;
      @(negedge clk);
      check(cfg_idx == 3'd2, "R6 held idx", cfg_idx, 2);
      check(cs_n == 5'b11011, "R6 held cs_n", cs_n, 5'b11011);

      // R8: wait stretch during this access
      ready_en = 1'b1; ready_in = 1'b1; #0;
      #1 check(wait_stretch == 1'b1, "R8 enabled high", wait_stretch, 1);
      ready_in = 1'b0;
      #1 check(wait_stretch == 1'b0, "R8 ready low", wait_stretch, 0);
      ready_en = 1'b0; ready_in = 1'b1;
      #1 check(wait_stretch == 1'b0, "R8 disabled", wait_stretch, 0);
      @(negedge clk);
      acc_strobe = 1'b0; ready_en = 1'b1;
      @(negedge clk);
      check(cs_n == 5'h1F, "R5 after hold access", cs_n, 5'h1F);
      check(wait_stretch == 1'b0, "R8 no access", wait_stretch, 0);
      ready_en = 1'b0; ready_in = 1'b0;

      // R7: segment line mapping
      for (int s = 0; s < 4; s++) begin
         logic [3:0] e;
         e = (s == 0) ? 4'd0 : (s == 1) ? 4'd2 : (s == 2) ? 4'd4 : 4'd8;
         space_sel = 2'(s);
         #1 check(seg_lines == e, "R7 seg lines", seg_lines, e);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule